// File: doc/BRIEF.md
# Global Bypass Attribute Register

This block is the control register that an I/O memory management unit consults while its translation machinery is globally switched off. Software reaches the register through a simple 32-bit port (register address, write data, write strobe, read data). The block also takes the global translation enable and a stream of device transaction requests. It answers every request with a registered classification: translate, bypass or abort.

The register holds a single bit that selects between two outcomes while translation is off. When the bit is 0, transactions pass through with their address unchanged. When it is 1, they are refused. The remaining attribute bits are stored and read back but have no other effect here. A write is accepted only when software sets the top bit of the word as a commit request. That bit is never stored, so software always reads it back as 0. While translation is on, the register has no influence on any response.

Top module: `gbypass_reg`

## Requirements
- R1: After reset, a read at register offset 0x44 returns 0x0000_1000. The abort bit (bit 20) is 0.
- R2: A write to offset 0x44 with bit 31 clear leaves the stored value unchanged and has no effect on transaction responses.
- R3: A write to offset 0x44 with bit 31 set stores the written word with bit 31 forced to 0, from the next clock on. A read at 0x44 never shows bit 31 set.
- R4: A read at any offset other than 0x44 returns 0. A write to any other offset leaves the stored value unchanged.
- R5: While the translation enable is 1, every request is answered with kind 0 (translate), whatever the stored abort bit.
- R6: While the translation enable is 0 and the stored bit 20 is 0, a request is answered with kind 1 (bypass), and the response address equals the request address.
- R7: While the translation enable is 0 and the stored bit 20 is 1, a request is answered with kind 2 (abort).
- R8: A response is valid exactly one clock after each valid request and at no other time. Back-to-back requests give back-to-back responses in order.
- R9: When a committing write and a request fall in the same cycle, the request is classified with the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | RA_W | Byte offset for register read and write |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data for reg_addr |
| xlat_en | input | 1 | Global translation enable |
| req_valid | input | 1 | Transaction request valid |
| req_addr | input | VA_W | Transaction address |
| resp_valid | output | 1 | Response valid, one clock after a request |
| resp_kind | output | 2 | 0 translate, 1 bypass, 2 abort |
| resp_addr | output | VA_W | Address returned with the response |

## Verification
The bench keeps the register offset, reset value and bit positions at their defaults, so software-visible behaviour is exercised at offset 0x44 and at its neighbours 0x40 and 0x48. It narrows the transaction address to 32 bits so that distinct, recognisable addresses can be checked for pass-through. With these settings, the bench can issue a commit write and a request in the same clock and verify that the classification uses the old value. It can also check each outcome while the translation enable switches back and forth.

// File: rtl/gbypass_reg.sv
module gbypass_reg #(
  parameter int RA_W = 12,
  parameter int VA_W = 48,
  parameter logic [RA_W-1:0] REG_OFFSET = 'h44,
  parameter logic [31:0] RESET_VAL = 32'h0000_1000,
  parameter int ABORT_BIT = 20,
  parameter int COMMIT_BIT = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  input  logic            reg_wr,
  output logic [31:0]     reg_rdata,
  input  logic            xlat_en,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_addr,
  output logic            resp_valid,
  output logic [1:0]      resp_kind,
  output logic [VA_W-1:0] resp_addr
);
  localparam logic [1:0]  KIND_XLATE  = 2'd0;
  localparam logic [1:0]  KIND_PASS   = 2'd1;
  localparam logic [1:0]  KIND_ABORT  = 2'd2;
  localparam logic [31:0] COMMIT_MASK = 32'd1 << COMMIT_BIT;

  logic [31:0] stored_q;
  logic        hit;
  logic        commit;
  logic [1:0]  kind_d;

  assign hit    = (reg_addr == REG_OFFSET);
  assign commit = reg_wr && hit && reg_wdata[COMMIT_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      stored_q <= RESET_VAL & ~COMMIT_MASK;
    else if (commit) stored_q <= reg_wdata & ~COMMIT_MASK;

  assign reg_rdata = hit ? stored_q : '0;

  assign kind_d = xlat_en             ? KIND_XLATE :
                  stored_q[ABORT_BIT] ? KIND_ABORT : KIND_PASS;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_kind  <= KIND_XLATE;
      resp_addr  <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_kind <= kind_d;
        resp_addr <= req_addr;
      end
    end
endmodule

// File: rtl/gbypass_reg_chk.sv
module gbypass_reg_chk #(
  parameter int RA_W = 12,
  parameter int VA_W = 48,
  parameter logic [RA_W-1:0] REG_OFFSET = 'h44,
  parameter logic [31:0] RESET_VAL = 32'h0000_1000,
  parameter int ABORT_BIT = 20,
  parameter int COMMIT_BIT = 31
) (
  input logic            clk,
  input logic            rst_n,
  input logic [RA_W-1:0] reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            reg_wr,
  input logic [31:0]     reg_rdata,
  input logic            xlat_en,
  input logic            req_valid,
  input logic [VA_W-1:0] req_addr,
  input logic            resp_valid,
  input logic [1:0]      resp_kind,
  input logic [VA_W-1:0] resp_addr,
  input logic [31:0]     stored_q
);
  assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> stored_q == (RESET_VAL & ~(32'd1 << COMMIT_BIT)));

  assert_plain_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_OFFSET && !reg_wdata[COMMIT_BIT]) |=> $stable(stored_q));

  assert_commit_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_OFFSET && reg_wdata[COMMIT_BIT]) |=>
      stored_q == ($past(reg_wdata) & ~(32'd1 << COMMIT_BIT)));

  assert_commit_never_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == REG_OFFSET |-> !reg_rdata[COMMIT_BIT]);

  assert_unmapped_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr != REG_OFFSET |-> reg_rdata == 32'd0);

  assert_unmapped_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != REG_OFFSET) |=> $stable(stored_q));

  assert_translate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_en) |=> resp_kind == 2'd0);

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_en && !stored_q[ABORT_BIT]) |=>
      (resp_kind == 2'd1 && resp_addr == $past(req_addr)));

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_en && stored_q[ABORT_BIT]) |=> resp_kind == 2'd2);

  assert_resp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_stray_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
endmodule

bind gbypass_reg gbypass_reg_chk #(
  .RA_W(RA_W), .VA_W(VA_W), .REG_OFFSET(REG_OFFSET), .RESET_VAL(RESET_VAL),
  .ABORT_BIT(ABORT_BIT), .COMMIT_BIT(COMMIT_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata), .xlat_en(xlat_en),
  .req_valid(req_valid), .req_addr(req_addr), .resp_valid(resp_valid),
  .resp_kind(resp_kind), .resp_addr(resp_addr), .stored_q(stored_q)
);

// File: tb/gbypass_reg_tb_top.sv
module gbypass_reg_tb_top;
  localparam int RA_W = 12;
  localparam int VA_W = 32;

  typedef struct {
    logic [1:0]      kind;
    logic [VA_W-1:0] addr;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_rdata;
  logic            xlat_en = 1'b0;
  logic            req_valid = 1'b0;
  logic [VA_W-1:0] req_addr = '0;
  logic            resp_valid;
  logic [1:0]      resp_kind;
  logic [VA_W-1:0] resp_addr;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  logic [31:0] model = 32'h0000_1000;

  always #4 clk = ~clk;

  gbypass_reg #(.RA_W(RA_W), .VA_W(VA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .xlat_en(xlat_en),
    .req_valid(req_valid), .req_addr(req_addr), .resp_valid(resp_valid),
    .resp_kind(resp_kind), .resp_addr(resp_addr)
  );

  function automatic logic [1:0] predict(input logic en);
    return en ? 2'd0 : (model[20] ? 2'd2 : 2'd1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_read(input logic [RA_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0; reg_addr = a;
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic reg_write(input logic [RA_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    if (a == 'h44 && d[31]) model = d & 32'h7fff_ffff;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_req(input logic en, input logic [VA_W-1:0] a, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; xlat_en = en; req_addr = a; req_valid = 1'b1;
    sb.push_back('{kind: predict(en), addr: a, tag: tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; reg_wr = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) begin
        check("R8 stray response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " kind"}, {30'd0, resp_kind}, {30'd0, e.kind});
        if (e.kind == 2'd1) check({e.tag, " addr"}, resp_addr, e.addr);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_read('h44, 32'h0000_1000, "R1 reset value");
    check("R8 idle after reset", {31'd0, resp_valid}, 32'd0);

    send_req(1'b1, 32'hA000_0010, "R5 translate");
    send_req(1'b0, 32'hB000_0020, "R6 bypass");
    idle(2);

    reg_write('h44, 32'h0010_0000);
    reg_read('h44, 32'h0000_1000, "R2 plain write ignored");
    send_req(1'b0, 32'hC000_0030, "R2 still bypass");
    idle(2);

    reg_write('h44, 32'h8010_1234);
    reg_read('h44, 32'h0010_1234, "R3 commit stored");
    send_req(1'b0, 32'hD000_0040, "R7 abort");
    send_req(1'b1, 32'hD000_0044, "R5 translate over abort");
    idle(2);

    reg_read('h48, 32'h0, "R4 unmapped read");
    reg_write('h40, 32'h8000_0000);
    reg_read('h40, 32'h0, "R4 unmapped read after write");
    reg_read('h44, 32'h0010_1234, "R4 unmapped write ignored");

    @(negedge clk);
    xlat_en = 1'b0; req_addr = 32'hE000_0050; req_valid = 1'b1;
    sb.push_back('{kind: predict(1'b0), addr: 32'hE000_0050, tag: "R9 old value seen"});
    reg_addr = 'h44; reg_wdata = 32'h8000_1000; reg_wr = 1'b1;
    model = 32'h0000_1000;
    @(negedge clk);
    reg_wr = 1'b0;
    xlat_en = 1'b0; req_addr = 32'hE000_0054;
    sb.push_back('{kind: predict(1'b0), addr: 32'hE000_0054, tag: "R9 new value next"});
    idle(2);

    for (int i = 0; i < 6; i++)
      send_req(i[0], 32'h1000_0000 + i * 4, "R8 back to back");
    idle(4);
    check("R8 queue drained", sb.size(), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule